// File: doc/BRIEF.md
# Inter-processor interrupt mailbox

This block lets any core of a multi-core cluster post a short message to any other core and raise an interrupt there. Every core owns an 8-byte window on a simple register bus. Its first word is the control register. The core writes it to send a message to a chosen destination, to acknowledge its own pending message, or to do both. Its second word is the status register. It shows the last message delivered to that core: the sender's index, a 16-bit payload and a pending flag.

The pending flag of each core drives that core's interrupt line directly. The line is a level signal: it stays high until the core acknowledges. The block has no interrupt inputs, and messages enter only through bus writes. The bus works in one cycle. A write takes effect at the clock edge where the write enable is high. Read data is combinational from the address. Every access is a full 32-bit word.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every interrupt output is low, and every status register reads 0x00000000.
- R2: Addresses are byte addresses and must be word aligned (bits 1:0 zero). The control register of core c is at 8*c and its status register is at 8*c+4.
- R3: A write to core s's control register with bit 30 (send) set and a destination d (bits 29:16) below NUM_CORES sets d's pending flag. The same write loads d's source field with s and d's payload with bits 15:0. Status reads as {bit31=0, bit30=pending, bits29:16=source, bits15:0=payload}.
- R4: A write to core c's control register with bit 31 (acknowledge) set clears c's pending flag. It does not change any other core, and it leaves c's source and payload fields unchanged.
- R5: Interrupt output c equals c's pending flag. It stays high with no bus activity until it is acknowledged.
- R6: If one write both acknowledges core c and sends a message to c, the new message wins. Pending stays set and the new source and payload are captured.
- R7: A message that reaches a core that is already pending replaces its source and payload, and pending stays set.
- R8: A send whose destination field is NUM_CORES or more changes nothing.
- R9: A control register always reads zero. Writes to a status register change nothing.
- R10: An access at or above 8*NUM_CORES, or with nonzero address bits 1:0, has no effect and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | NUM_CORES | Level interrupt, one per core |

## Verification
The hardest case to reach is a single write that both acknowledges and sends to the same core. Only a core that sends to itself can produce it, because the acknowledge always targets the register's owner. The bench reaches it by first making core 3 pending from another core. Core 3 then writes its own control word with both flags set, its own index as destination and a fresh payload. A second case needs care: a message that arrives while the core is already pending. The bench stacks two senders on one idle destination and shows that only the later message survives.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] sel;
  logic             is_stat, valid, ctrl_wr, send, ack, dst_ok;
  logic [13:0]      dst;

  logic [NUM_CORES-1:0] pend;
  logic [13:0]          src_q [NUM_CORES];
  logic [15:0]          pay_q [NUM_CORES];

  assign sel     = bus_addr[ADDR_W-1:3];
  assign is_stat = bus_addr[2];
  assign valid   = (bus_addr[1:0] == 2'b00) && (32'(sel) < NUM_CORES);
  assign ctrl_wr = bus_we && valid && !is_stat;
  assign send    = ctrl_wr && bus_wdata[30];
  assign ack     = ctrl_wr && bus_wdata[31];
  assign dst     = bus_wdata[29:16];
  assign dst_ok  = 32'(dst) < NUM_CORES;
  assign irq     = pend;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit, clr;
    assign hit = send && dst_ok && (dst == 14'(c));
    assign clr = ack && (sel == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[c]  <= 1'b0;
        src_q[c] <= '0;
        pay_q[c] <= '0;
      end else if (hit) begin
        pend[c]  <= 1'b1;
        src_q[c] <= 14'(sel);
        pay_q[c] <= bus_wdata[15:0];
      end else if (clr) begin
        pend[c]  <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (valid && is_stat && sel == IDX_W'(c))
        bus_rdata = {1'b0, pend[c], src_q[c], pay_q[c]};
  end
endmodule

// File: rtl/ipi_mailbox_checks.sv
module ipi_mailbox_checks #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CORES-1:0] irq
);
  logic ctl_w;
  assign ctl_w = bus_we && bus_addr[1:0] == 2'b00 && !bus_addr[2]
                 && (32'(bus_addr >> 3) < NUM_CORES);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    a_r3_send_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && bus_wdata[30] && bus_wdata[29:16] == 14'(c)) |=> irq[c]);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && bus_wdata[31] && 32'(bus_addr >> 3) == c
       && !(bus_wdata[30] && bus_wdata[29:16] == 14'(c))) |=> !irq[c]);
  end

  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(irq));
  a_r9_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[2] |-> bus_rdata == 32'd0);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[31]);
endmodule

bind ipi_mailbox ipi_mailbox_checks #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

// File: tb/ipi_mailbox_test.sv
module ipi_mailbox_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(N), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] msg(int dst, logic [15:0] p, bit ack = 0);
    return {ack, 1'b1, 14'(dst), p};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    for (int c = 0; c < N; c++) begin rd(8'(8*c+4), d); check("R1 status", d, 0); end
  endtask

  task automatic t_send;
    logic [31:0] d;
    wr(8'd8, msg(2, 16'hA5A5));
    rd(8'd20, d); check("R3 status of core2", d, 32'h4001_A5A5);
    check("R5 irq", 32'(irq), 32'b0100);
    rd(8'd16, d); check("R9 ctrl reads zero", d, 0);
    rd(8'd0, d);  check("R2 core0 ctrl zero", d, 0);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(8'd0, 32'h8000_0000);
    check("R4 other core ack no effect", 32'(irq), 32'b0100);
    wr(8'd16, 32'h8000_0000);
    check("R4 irq cleared", 32'(irq), 0);
    rd(8'd20, d); check("R4 fields kept", d, 32'h0001_A5A5);
  endtask

  task automatic t_overwrite;
    logic [31:0] d;
    wr(8'd0, msg(3, 16'h1111));
    wr(8'd16, msg(3, 16'h2222));
    repeat (5) @(negedge clk);
    check("R5 level held", 32'(irq), 32'b1000);
    rd(8'd28, d); check("R7 overwrite", d, 32'h4002_2222);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    wr(8'd24, msg(3, 16'h3333, 1));
    check("R6 irq stays", 32'(irq), 32'b1000);
    rd(8'd28, d); check("R6 new msg", d, 32'h4003_3333);
    wr(8'd24, 32'h8000_0000);
    check("R4 ack core3", 32'(irq), 0);
  endtask

  task automatic t_baddst;
    wr(8'd8, msg(4, 16'hBEEF));
    check("R8 dst=N", 32'(irq), 0);
    wr(8'd8, msg(14'h3FFF, 16'hBEEF));
    check("R8 dst max", 32'(irq), 0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    wr(8'd32, msg(0, 16'h7777));
    check("R10 out of range write", 32'(irq), 0);
    wr(8'd1, msg(0, 16'h7777));
    check("R10 misaligned write", 32'(irq), 0);
    wr(8'd4, 32'h4003_9999);
    rd(8'd4, d); check("R9 status write ignored", d, 0);
    wr(8'd0, msg(0, 16'h4242));
    rd(8'd4, d); check("R3 self send", d, 32'h4000_4242);
    rd(8'd5, d); check("R10 misaligned read", d, 0);
    rd(8'd36, d); check("R10 out of range read", d, 0);
    wr(8'd0, 32'h8000_0000);
    check("R4 ack core0", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_send(); t_ack(); t_overwrite(); t_simul(); t_baddst(); t_range();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule